// File: doc/BRIEF.md
# Predicate shadow controller

This unit sits at register-fetch time in an in-order pipeline. For every instruction slot issued in a cycle it decides whether the instruction really executes or travels on as a no-op. It keeps a single condition bit that compare instructions write. A shadow-setup instruction loads a then/else mask that covers the instructions after it. Each covered instruction then runs only when the condition bit agrees with its mask position. No branches are needed inside the covered region.

Outside a shadow, each instruction carries a 2-bit tag. The tag makes the instruction unconditional, true-only or false-only. The slots of one issue group are taken oldest first, with slot 0 the oldest. A younger slot therefore sees the predicate and shadow state as the older slots in the same group have left it. A suppressed instruction is not removed from the stream. It still occupies its slot and consumes its mask position, but its enable is low.

Top module: `pred_shadow_ctrl`

## Requirements
- R1: After reset the predicate is false and no shadow is active, so an untagged instruction executes, a true-only one is suppressed and a false-only one executes.
- R2: An executing compare instruction (kind 01) sets the predicate to its compare-result input. The new value applies to younger slots in the same cycle and to all later cycles.
- R3: With no shadow active, tag 00 or 11 executes unconditionally, tag 01 executes only when the predicate is true, and tag 10 executes only when it is false.
- R4: Two tagged instructions in one issue group each get their own enable, both tested against the same predicate unless an older compare in the group changed it.
- R5: An executing setup instruction (kind 10) loads its mask and length. The next valid instructions, in slot order and starting with younger slots of the same group, take mask bits LSB first. A bit of 1 executes only when the predicate is true and a bit of 0 only when it is false. The tags of covered instructions are ignored.
- R6: An invalid slot has its enable low and consumes no mask position.
- R7: Once as many covered instructions as the loaded length have issued, tag rules apply again from the next valid instruction.
- R8: A length of 0 starts no shadow. A length above the mask width (8) covers exactly 8 instructions.
- R9: A setup instruction that executes inside a shadow first consumes its own position and then replaces whatever remains with its new mask. A suppressed setup instruction changes nothing.
- R10: A compare instruction that is suppressed, whether by its tag or by its mask position, leaves the predicate unchanged.
- R11: While flush is high all enables are low and the shadow is cleared at the next edge. The predicate keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush: kill this group and drop the shadow |
| slotValid | input | SLOTS | Slot carries an instruction |
| slotKind | input | SLOTS x 2 | 00 plain, 01 compare, 10 shadow setup, 11 plain |
| slotTag | input | SLOTS x 2 | 00 always, 01 if-true, 10 if-false, 11 always |
| slotCmp | input | SLOTS | Compare result of a compare slot |
| slotMask | input | SLOTS x 8 | Then(1)/else(0) mask of a setup slot, LSB first |
| slotLen | input | SLOTS x 4 | Number of covered instructions of a setup slot |
| execEn | output | SLOTS | Execute enable per slot |

## Verification
The delicate cases arise when two of the unit's functions meet inside one issue group. In one case, an older slot rewrites the predicate or loads a new shadow, and the younger slot in the same cycle is judged against that update. In the other, a setup or compare instruction is itself covered by a mask position. The directed tasks set this up by placing a compare or setup in slot 0 and a tagged or covered instruction in slot 1. The outcome is judged both from that cycle's enables and from the enables in the following cycles, which show whether the stored predicate and the remaining mask were left in the right state.

// File: rtl/pred_shadow_pkg.sv
`timescale 1ns/1ps
package pred_shadow_pkg;
  localparam int MASK_W = 8;
  localparam int LEN_W  = $clog2(MASK_W + 1);

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_CMP   = 2'b01,
    KIND_SETUP = 2'b10,
    KIND_RSVD  = 2'b11
  } slotKind_e;

  typedef enum logic [1:0] {
    TAG_ALWAYS  = 2'b00,
    TAG_IFTRUE  = 2'b01,
    TAG_IFFALSE = 2'b10,
    TAG_ALT     = 2'b11
  } slotTag_e;

  // strobes from control to the state datapath
  typedef struct packed {
    logic              predWr;
    logic              predNew;
    logic              shClear;
    logic              shLoad;
    logic [MASK_W-1:0] loadMask;
    logic [LEN_W-1:0]  loadLen;
    logic [LEN_W-1:0]  advance;
  } shadowStrobe_t;
endpackage

// File: rtl/pred_shadow_dp.sv
`timescale 1ns/1ps
module pred_shadow_dp
  import pred_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  shadowStrobe_t     strobe,
  output logic              predQ,
  output logic [MASK_W-1:0] maskQ,
  output logic [LEN_W-1:0]  remQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predQ <= 1'b0;
      maskQ <= '0;
      remQ  <= '0;
    end else begin
      if (strobe.predWr) predQ <= strobe.predNew;
      if (strobe.shClear) begin
        maskQ <= '0;
        remQ  <= '0;
      end else if (strobe.shLoad) begin
        maskQ <= strobe.loadMask;
        remQ  <= strobe.loadLen;
      end else begin
        maskQ <= maskQ >> strobe.advance;
        remQ  <= remQ - strobe.advance;
      end
    end
  end
endmodule

// File: rtl/pred_shadow_ctl.sv
`timescale 1ns/1ps
module pred_shadow_ctl
  import pred_shadow_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic                          flush,
  input  logic [SLOTS-1:0]              slotValid,
  input  logic [SLOTS-1:0][1:0]         slotKind,
  input  logic [SLOTS-1:0][1:0]         slotTag,
  input  logic [SLOTS-1:0]              slotCmp,
  input  logic [SLOTS-1:0][MASK_W-1:0]  slotMask,
  input  logic [SLOTS-1:0][LEN_W-1:0]   slotLen,
  input  logic                          predQ,
  input  logic [MASK_W-1:0]             maskQ,
  input  logic [LEN_W-1:0]              remQ,
  output logic [SLOTS-1:0]              execEn,
  output shadowStrobe_t                 strobe
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MASK_W);

  logic [SLOTS-1:0][LEN_W-1:0] lenClamp;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_clamp
      assign lenClamp[g] = (slotLen[g] > LEN_MAX) ? LEN_MAX : slotLen[g];
    end
  endgenerate

  // running state while walking the group oldest slot first
  logic              curPred;
  logic [MASK_W-1:0] curMask;
  logic [LEN_W-1:0]  curRem;
  logic              loaded;
  logic              wrote;
  logic [LEN_W-1:0]  adv;
  logic              en;

  always_comb begin
    curPred = predQ;
    curMask = maskQ;
    curRem  = remQ;
    loaded  = 1'b0;
    wrote   = 1'b0;
    adv     = '0;
    en      = 1'b0;
    execEn  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      en = 1'b0;
      if (slotValid[i] && !flush) begin
        if (curRem != '0) begin
          en      = curMask[0] ? curPred : !curPred;
          curMask = curMask >> 1;
          curRem  = curRem - LEN_W'(1);
          if (!loaded) adv = adv + LEN_W'(1);
        end else begin
          case (slotTag_e'(slotTag[i]))
            TAG_IFTRUE:  en = curPred;
            TAG_IFFALSE: en = !curPred;
            default:     en = 1'b1;
          endcase
        end
        if (en) begin
          if (slotKind_e'(slotKind[i]) == KIND_CMP) begin
            curPred = slotCmp[i];
            wrote   = 1'b1;
          end else if (slotKind_e'(slotKind[i]) == KIND_SETUP) begin
            curMask = slotMask[i];
            curRem  = lenClamp[i];
            loaded  = 1'b1;
          end
        end
      end
      execEn[i] = en;
    end
    strobe.predWr   = wrote;
    strobe.predNew  = curPred;
    strobe.shClear  = flush;
    strobe.shLoad   = loaded;
    strobe.loadMask = curMask;
    strobe.loadLen  = curRem;
    strobe.advance  = adv;
  end
endmodule

// File: rtl/pred_shadow_ctrl.sv
`timescale 1ns/1ps
module pred_shadow_ctrl
  import pred_shadow_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flush,
  input  logic [SLOTS-1:0]              slotValid,
  input  logic [SLOTS-1:0][1:0]         slotKind,
  input  logic [SLOTS-1:0][1:0]         slotTag,
  input  logic [SLOTS-1:0]              slotCmp,
  input  logic [SLOTS-1:0][MASK_W-1:0]  slotMask,
  input  logic [SLOTS-1:0][LEN_W-1:0]   slotLen,
  output logic [SLOTS-1:0]              execEn
);
  shadowStrobe_t     strobe;
  logic              predQ;
  logic [MASK_W-1:0] maskQ;
  logic [LEN_W-1:0]  remQ;

  pred_shadow_ctl #(.SLOTS(SLOTS)) i_ctl (
    .flush(flush), .slotValid(slotValid), .slotKind(slotKind),
    .slotTag(slotTag), .slotCmp(slotCmp), .slotMask(slotMask),
    .slotLen(slotLen), .predQ(predQ), .maskQ(maskQ), .remQ(remQ),
    .execEn(execEn), .strobe(strobe)
  );

  pred_shadow_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .predQ(predQ), .maskQ(maskQ), .remQ(remQ)
  );
endmodule

// File: rtl/pred_shadow_chk.sv
`timescale 1ns/1ps
module pred_shadow_chk
  import pred_shadow_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  flush,
  input logic [SLOTS-1:0]      slotValid,
  input logic [SLOTS-1:0][1:0] slotKind,
  input logic [SLOTS-1:0][1:0] slotTag,
  input logic [SLOTS-1:0]      execEn,
  input logic                  predQ,
  input logic [LEN_W-1:0]      remQ
);
  logic [SLOTS-1:0] isCmp;
  always_comb
    for (int i = 0; i < SLOTS; i++) isCmp[i] = (slotKind[i] == 2'b01);

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      p_invalid_off_r6: assert property (@(posedge clk) disable iff (!rstN)
        !slotValid[g] |-> !execEn[g]);
    end
  endgenerate

  p_flush_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> execEn == '0);

  p_flush_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> remQ == '0);

  p_pred_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((execEn & isCmp) == '0) |=> $stable(predQ));

  p_rem_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid == '0 && !flush) |=> $stable(remQ));

  p_rem_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    remQ <= LEN_W'(MASK_W));

  p_plain_exec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (remQ == '0 && slotValid[0] && !flush && slotTag[0] == 2'b00) |-> execEn[0]);
endmodule

bind pred_shadow_ctrl pred_shadow_chk #(.SLOTS(SLOTS)) i_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .slotValid(slotValid),
  .slotKind(slotKind), .slotTag(slotTag), .execEn(execEn),
  .predQ(predQ), .remQ(remQ)
);

// File: tb/test_pred_shadow_ctrl.sv
`timescale 1ns/1ps
module test_pred_shadow_ctrl;
  import pred_shadow_pkg::*;
  localparam int SLOTS = 2;

  logic                         clk = 1'b0;
  logic                         rstN = 1'b0;
  logic                         flush = 1'b0;
  logic [SLOTS-1:0]             slotValid = '0;
  logic [SLOTS-1:0][1:0]        slotKind = '0;
  logic [SLOTS-1:0][1:0]        slotTag = '0;
  logic [SLOTS-1:0]             slotCmp = '0;
  logic [SLOTS-1:0][MASK_W-1:0] slotMask = '0;
  logic [SLOTS-1:0][LEN_W-1:0]  slotLen = '0;
  logic [SLOTS-1:0]             execEn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pred_shadow_ctrl #(.SLOTS(SLOTS)) i_pred_shadow_ctrl (.*);

  always #2.5 clk = ~clk;

  task automatic idle();
    flush = 1'b0; slotValid = '0; slotKind = '0; slotTag = '0;
    slotCmp = '0; slotMask = '0; slotLen = '0;
  endtask

  task automatic put(int i, logic [1:0] kind, logic [1:0] tag, logic cmp,
                     logic [MASK_W-1:0] mask, logic [LEN_W-1:0] len);
    slotValid[i] = 1'b1; slotKind[i] = kind; slotTag[i] = tag;
    slotCmp[i] = cmp; slotMask[i] = mask; slotLen[i] = len;
  endtask

  task automatic expectEn(logic [SLOTS-1:0] exp, string req, string what);
    #1;
    total++;
    if (execEn !== exp) begin
      bad++;
      $display("FAIL %s %s: execEn=%b expected=%b", req, what, execEn, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic setPred(logic v);
    put(0, 2'b01, 2'b00, v, '0, '0);
    expectEn(2'b01, "R2", "predicate set");
    tick();
  endtask

  task automatic t_reset();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b01, 0, '0, '0);
    expectEn(2'b01, "R1", "reset untagged/if-true");
    slotTag[1] = 2'b10;
    expectEn(2'b11, "R1", "reset if-false");
    tick();
  endtask

  task automatic t_tags();
    put(0, 2'b01, 2'b00, 1, '0, '0);
    expectEn(2'b01, "R2", "compare writes true");
    tick();
    put(0, 2'b00, 2'b01, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b01, "R4", "pair under true");
    slotTag[0] = 2'b11;
    expectEn(2'b01, "R3", "tag 11 always");
    tick();
    put(0, 2'b01, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b11, "R4", "slot1 sees slot0 compare");
    tick();
    put(0, 2'b00, 2'b01, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b10, "R3", "pair under false");
    tick();
  endtask

  task automatic t_suppressed_cmp();
    setPred(0);
    put(0, 2'b01, 2'b01, 1, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b10, "R10", "tag-suppressed compare");
    tick();
    put(0, 2'b00, 2'b01, 0, '0, '0);
    expectEn(2'b00, "R10", "predicate still false");
    tick();
  endtask

  task automatic t_shadow();
    put(0, 2'b01, 2'b00, 1, '0, '0);
    put(1, 2'b10, 2'b00, 0, 8'b0001_1111, 4'd8);
    expectEn(2'b11, "R5", "compare+setup");
    tick();
    put(0, 2'b00, 2'b10, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b11, "R5", "then positions ignore tags");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b01, "R6", "slot1 idle");
    tick();
    put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b10, "R6", "slot0 idle");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b01, "R5", "then/else boundary");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b00, "R5", "else positions");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b01, "R7", "join point");
    tick();
  endtask

  task automatic t_shadow_cmp();
    setPred(1);
    put(0, 2'b10, 2'b00, 0, 8'b0000_0101, 4'd4);
    put(1, 2'b01, 2'b00, 0, '0, '0);
    expectEn(2'b11, "R2", "covered compare executes");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b01, 2'b00, 1, '0, '0);
    expectEn(2'b01, "R10", "mask-suppressed compare");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b11, "R10", "predicate kept false");
    tick();
  endtask

  task automatic t_replace();
    setPred(0);
    put(0, 2'b10, 2'b00, 0, 8'h00, 4'd8);
    expectEn(2'b01, "R5", "all-else setup");
    tick();
    put(0, 2'b10, 2'b00, 0, 8'hFF, 4'd3); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b01, "R9", "replacing setup");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b00, "R9", "new mask governs");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b01, 0, '0, '0);
    expectEn(2'b01, "R9", "old shadow gone");
    tick();
    put(0, 2'b10, 2'b00, 0, 8'hFF, 4'd4);
    expectEn(2'b01, "R5", "all-then setup");
    tick();
    put(0, 2'b10, 2'b00, 0, 8'h00, 4'd8); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b00, "R9", "suppressed setup");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b00, "R9", "old mask intact");
    tick();
    put(0, 2'b00, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b11, "R7", "shadow over");
    tick();
  endtask

  task automatic t_len();
    setPred(0);
    put(0, 2'b10, 2'b00, 0, 8'hFF, 4'd0); put(1, 2'b00, 2'b01, 0, '0, '0);
    expectEn(2'b01, "R8", "zero length");
    tick();
    put(0, 2'b10, 2'b00, 0, 8'h00, 4'd15); put(1, 2'b00, 2'b01, 0, '0, '0);
    expectEn(2'b11, "R8", "overlong setup");
    tick();
    for (int k = 0; k < 3; k++) begin
      put(0, 2'b00, 2'b01, 0, '0, '0); put(1, 2'b00, 2'b01, 0, '0, '0);
      expectEn(2'b11, "R8", "clamped shadow body");
      tick();
    end
    put(0, 2'b00, 2'b01, 0, '0, '0); put(1, 2'b00, 2'b01, 0, '0, '0);
    expectEn(2'b01, "R8", "clamped to 8");
    tick();
  endtask

  task automatic t_flush();
    put(0, 2'b01, 2'b00, 1, '0, '0); put(1, 2'b10, 2'b00, 0, 8'h00, 4'd8);
    expectEn(2'b11, "R2", "compare+setup before flush");
    tick();
    flush = 1'b1;
    put(0, 2'b01, 2'b00, 0, '0, '0); put(1, 2'b00, 2'b00, 0, '0, '0);
    expectEn(2'b00, "R11", "flush kills group");
    tick();
    put(0, 2'b00, 2'b01, 0, '0, '0); put(1, 2'b00, 2'b10, 0, '0, '0);
    expectEn(2'b01, "R11", "shadow cleared, predicate kept");
    tick();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_tags();
    t_suppressed_cmp();
    t_shadow();
    t_shadow_cmp();
    t_replace();
    t_len();
    t_flush();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule